// File: doc/BRIEF.md
# Wide Register Write Collector

This block sits on the host write path of a chip whose control registers are 128 bits wide while the host issues 32-bit writes. Each host write carries a byte address and one dword of data. A write that targets a wide register goes into a single shared collector. The collector remembers which register it is filling and which of the four dwords have arrived. The register is committed in one cycle, as a 128-bit value, only when every dword is present. Writes to ordinary 32-bit registers skip the collector and are forwarded unchanged one cycle later.

Two wide registers in every page are descriptor pointers, which software only writes. These registers commit whenever their top dword is written. If the collector cannot supply the lower three dwords at that moment, those 96 bits are committed as zero. A write to a timer-command register in page 0 wipes the collector clean. The address space is split into pages. The byte address is the page number times 0x2000 plus an offset inside the page.

Top module: `wide_reg_collector`

## Requirements
- R1: After reset, `commit_valid` and `narrow_valid` are low and the collector is empty, so the first wide write is accepted by any register.
- R2: A non-descriptor wide register commits once all four of its dwords (index = `wr_addr[3:2]`) have been collected, in any order. The commit is a one-cycle `commit_valid` pulse in the cycle after the completing write. `commit_addr` is the 16-byte-aligned register address, and dword i sits at `commit_data[32*i+31:32*i]`.
- R3: A wide write that leaves the owner's set of dwords incomplete produces no commit.
- R4: Writing a dword that is already collected replaces its value. The later value is the one committed.
- R5: A write to dword 3 of a descriptor register (page offsets 0x830 and 0xA10) always produces a commit in the next cycle, with `commit_data[127:96]` equal to the written data.
- R6: When such a commit finds the collector owned by the same register and holding dwords 0 to 2, those dwords are committed. Otherwise `commit_data[95:0]` is zero.
- R7: A wide write to a register other than the current owner is dropped while the collector is non-empty, unless it is a descriptor top dword. The dropped write causes no commit and leaves the collected data and owner unchanged.
- R8: A descriptor top-dword commit for a register that does not own the collector leaves the collector's owner and contents intact.
- R9: A narrow write to page 0 offset 0x420 empties the collector and releases its owner. The same offset in any other page does not.
- R10: Offsets below 0x800 or at 0x1000 and above are narrow. A narrow write appears on `narrow_valid`/`narrow_addr`/`narrow_data` in the next cycle, never together with a commit, and leaves the collector unchanged (apart from R9).
- R11: Byte address = page × 0x2000 + offset. Offsets 0x800 to 0xFFF in each page form 128-bit registers, and each page decodes on its own.
- R12: `wr_ready` is high in every cycle, so one write is accepted per cycle, including back-to-back writes.
- R13: After a commit by its owner, the collector is empty, and a different register can claim it at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Host write request |
| wr_ready | output | 1 | Write accepted (always high) |
| wr_addr | input | ADDR_W | Dword-aligned byte address |
| wr_data | input | 32 | Write data |
| commit_valid | output | 1 | One-cycle wide-register commit pulse |
| commit_addr | output | ADDR_W | 16-byte-aligned address of committed register |
| commit_data | output | 128 | Committed register value |
| narrow_valid | output | 1 | Narrow register write pulse |
| narrow_addr | output | ADDR_W | Narrow register address |
| narrow_data | output | 32 | Narrow register data |

## Verification
The bench builds the block with `PAGE_W = 2`, which gives four pages. At this size, a random mix of writes regularly sends the same offset to page 0 and to other pages. It can therefore show that the timer-command clear is tied to page 0 and that the descriptor decode repeats in every page. The random writes are drawn from a handful of offsets, so ownership clashes, dropped foreign writes and partial descriptor commits occur often alongside the directed sequences.

// File: rtl/wrc_pkg.sv
package wrc_pkg;
    localparam int DWORD_W  = 32;
    localparam int LANES    = 4;
    localparam int WIDE_W   = DWORD_W * LANES;
    localparam int OFFS_W   = 13;               // 0x2000-byte page stride
    localparam logic [OFFS_W-1:0] PTR_A_OFS = 13'h830;
    localparam logic [OFFS_W-1:0] PTR_B_OFS = 13'hA10;
    localparam logic [OFFS_W-1:0] TMR_OFS   = 13'h420;

    typedef enum logic [1:0] {
        KIND_NARROW = 2'd0,
        KIND_WIDE   = 2'd1,
        KIND_PTR    = 2'd2
    } wr_kind_e;

    typedef struct packed {
        wr_kind_e   kind;
        logic [1:0] lane;
        logic       tmr_hit;
    } wr_class_t;

    function automatic wr_class_t classify(input logic [OFFS_W-1:0] ofs,
                                           input logic page_zero);
        wr_class_t c;
        c.lane    = ofs[3:2];
        c.tmr_hit = page_zero && (ofs == TMR_OFS);
        if (ofs[12:11] != 2'b01)
            c.kind = KIND_NARROW;
        else if (ofs[12:4] == PTR_A_OFS[12:4] || ofs[12:4] == PTR_B_OFS[12:4])
            c.kind = KIND_PTR;
        else
            c.kind = KIND_WIDE;
        return c;
    endfunction
endpackage

// File: rtl/wrc_decode.sv
module wrc_decode
    import wrc_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic [ADDR_W-1:0] addr,
    output wr_class_t         cls,
    output logic [ADDR_W-5:0] blk
);
    localparam int PAGE_W = ADDR_W - OFFS_W;

    logic [PAGE_W-1:0] page;

    always_comb begin
        page = addr[ADDR_W-1:OFFS_W];
        cls  = classify(addr[OFFS_W-1:0], page == '0);
        blk  = addr[ADDR_W-1:4];
    end
endmodule

// File: rtl/wrc_narrow_port.sv
module wrc_narrow_port
    import wrc_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DWORD_W-1:0] data,
    output logic               out_valid,
    output logic [ADDR_W-1:0]  out_addr,
    output logic [DWORD_W-1:0] out_data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_addr  <= '0;
            out_data  <= '0;
        end else begin
            out_valid <= req;
            if (req) begin
                out_addr <= addr;
                out_data <= data;
            end
        end
    end
endmodule

// File: rtl/wrc_collector.sv
module wrc_collector
    import wrc_pkg::*;
#(
    parameter int BLK_W = 11
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req,
    input  logic               is_ptr,
    input  logic [BLK_W-1:0]   blk,
    input  logic [1:0]         lane,
    input  logic [DWORD_W-1:0] wdata,
    input  logic               flush,
    output logic               cmt_valid,
    output logic [BLK_W-1:0]   cmt_blk,
    output logic [WIDE_W-1:0]  cmt_data,
    output logic [LANES-1:0]   held_mask,
    output logic [BLK_W-1:0]   held_blk
);
    logic [LANES-1:0][DWORD_W-1:0] buf_q;
    logic [LANES-1:0][DWORD_W-1:0] merged;
    logic [LANES-1:0]              lane_bit;
    logic [LANES-1:0]              next_mask;
    logic                          empty;
    logic                          owns;
    logic                          same_owner;
    logic                          full;
    logic                          ptr_top;

    for (genvar g = 0; g < LANES; g++) begin : g_merge
        assign merged[g] = (lane == g[1:0]) ? wdata : buf_q[g];
    end

    always_comb begin
        empty      = (held_mask == '0);
        same_owner = !empty && (held_blk == blk);
        owns       = empty || same_owner;
        lane_bit   = LANES'(1) << lane;
        next_mask  = held_mask | lane_bit;
        full       = owns && (next_mask == '1);
        ptr_top    = is_ptr && (lane == 2'd3);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_q     <= '0;
            held_mask <= '0;
            held_blk  <= '0;
            cmt_valid <= 1'b0;
            cmt_blk   <= '0;
            cmt_data  <= '0;
        end else begin
            cmt_valid <= 1'b0;
            if (flush) begin
                held_mask <= '0;
                held_blk  <= '0;
            end else if (req) begin
                if (ptr_top) begin
                    cmt_valid <= 1'b1;
                    cmt_blk   <= blk;
                    cmt_data  <= full ? merged : {wdata, {(WIDE_W-DWORD_W){1'b0}}};
                    if (same_owner)
                        held_mask <= '0;
                end else if (owns) begin
                    buf_q[lane] <= wdata;
                    held_blk    <= blk;
                    if (full) begin
                        cmt_valid <= 1'b1;
                        cmt_blk   <= blk;
                        cmt_data  <= merged;
                        held_mask <= '0;
                    end else begin
                        held_mask <= next_mask;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/wide_reg_collector.sv
module wide_reg_collector
    import wrc_pkg::*;
#(
    parameter int PAGE_W = 2,
    localparam int ADDR_W = OFFS_W + PAGE_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_valid,
    output logic                 wr_ready,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [31:0]          wr_data,
    output logic                 commit_valid,
    output logic [ADDR_W-1:0]    commit_addr,
    output logic [127:0]         commit_data,
    output logic                 narrow_valid,
    output logic [ADDR_W-1:0]    narrow_addr,
    output logic [31:0]          narrow_data
);
    localparam int BLK_W = ADDR_W - 4;

    wr_class_t        cls;
    logic [BLK_W-1:0] blk;
    logic [BLK_W-1:0] cmt_blk;
    logic [LANES-1:0] coll_mask;
    logic [BLK_W-1:0] coll_blk;
    logic             narrow_req;
    logic             wide_req;
    logic             tmr_flush;

    assign wr_ready    = 1'b1;
    assign narrow_req  = wr_valid && (cls.kind == KIND_NARROW);
    assign wide_req    = wr_valid && (cls.kind != KIND_NARROW);
    assign tmr_flush   = narrow_req && cls.tmr_hit;
    assign commit_addr = {cmt_blk, 4'b0000};

    wrc_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr (wr_addr),
        .cls  (cls),
        .blk  (blk)
    );

    wrc_collector #(.BLK_W(BLK_W)) u_coll (
        .clk       (clk),
        .rst       (rst),
        .req       (wide_req),
        .is_ptr    (cls.kind == KIND_PTR),
        .blk       (blk),
        .lane      (cls.lane),
        .wdata     (wr_data),
        .flush     (tmr_flush),
        .cmt_valid (commit_valid),
        .cmt_blk   (cmt_blk),
        .cmt_data  (commit_data),
        .held_mask (coll_mask),
        .held_blk  (coll_blk)
    );

    wrc_narrow_port #(.ADDR_W(ADDR_W)) u_narrow (
        .clk       (clk),
        .rst       (rst),
        .req       (narrow_req),
        .addr      (wr_addr),
        .data      (wr_data),
        .out_valid (narrow_valid),
        .out_addr  (narrow_addr),
        .out_data  (narrow_data)
    );
endmodule

// File: rtl/wrc_checker.sv
module wrc_checker
    import wrc_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_valid,
    input logic              wr_ready,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [31:0]       wr_data,
    input logic              commit_valid,
    input logic [127:0]      commit_data,
    input logic              narrow_valid,
    input logic [ADDR_W-1:0] narrow_addr,
    input logic [31:0]       narrow_data,
    input logic [3:0]        held_mask,
    input logic [ADDR_W-5:0] held_blk
);
    wr_class_t c;
    logic      is_narrow;
    logic      ptr_top;
    logic      foreign;

    always_comb begin
        c         = classify(wr_addr[OFFS_W-1:0], wr_addr[ADDR_W-1:OFFS_W] == '0);
        is_narrow = (c.kind == KIND_NARROW);
        ptr_top   = (c.kind == KIND_PTR) && (c.lane == 2'd3);
        foreign   = !is_narrow && (held_mask != '0) && (held_blk != wr_addr[ADDR_W-1:4]);
    end

    assert_always_ready_R12: assert property (@(posedge clk) disable iff (rst)
        wr_ready);

    assert_no_overlap_R10: assert property (@(posedge clk) disable iff (rst)
        !(commit_valid && narrow_valid));

    assert_narrow_forward_R10: assert property (@(posedge clk) disable iff (rst)
        wr_valid && is_narrow |=> narrow_valid && narrow_data == $past(wr_data)
                                  && narrow_addr == $past(wr_addr));

    assert_narrow_keeps_R10: assert property (@(posedge clk) disable iff (rst)
        wr_valid && is_narrow && !c.tmr_hit |=> $stable(held_mask) && $stable(held_blk));

    assert_timer_clear_R9: assert property (@(posedge clk) disable iff (rst)
        wr_valid && c.tmr_hit |=> held_mask == '0);

    assert_ptr_top_R5: assert property (@(posedge clk) disable iff (rst)
        wr_valid && ptr_top |=> commit_valid && commit_data[127:96] == $past(wr_data));

    assert_foreign_drop_R7: assert property (@(posedge clk) disable iff (rst)
        wr_valid && foreign && !ptr_top |=> !commit_valid && $stable(held_mask)
                                          && $stable(held_blk));

    assert_ptr_foreign_keeps_R8: assert property (@(posedge clk) disable iff (rst)
        wr_valid && foreign && ptr_top |=> $stable(held_mask) && $stable(held_blk));
endmodule

bind wide_reg_collector wrc_checker #(.ADDR_W(ADDR_W)) chk (
    .clk          (clk),
    .rst          (rst),
    .wr_valid     (wr_valid),
    .wr_ready     (wr_ready),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .commit_valid (commit_valid),
    .commit_data  (commit_data),
    .narrow_valid (narrow_valid),
    .narrow_addr  (narrow_addr),
    .narrow_data  (narrow_data),
    .held_mask    (coll_mask),
    .held_blk     (coll_blk)
);

// File: tb/wide_reg_collector_test.sv
module wide_reg_collector_test;
    localparam int PAGE_W = 2;
    localparam int ADDR_W = 13 + PAGE_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_valid = 1'b0;
    logic              wr_ready;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [31:0]       wr_data = '0;
    logic              commit_valid;
    logic [ADDR_W-1:0] commit_addr;
    logic [127:0]      commit_data;
    logic              narrow_valid;
    logic [ADDR_W-1:0] narrow_addr;
    logic [31:0]       narrow_data;

    int checks = 0;
    int fails  = 0;

    // bench reference state
    logic [31:0]       m_buf [4];
    logic [3:0]        m_mask = '0;
    logic [ADDR_W-5:0] m_blk  = '0;

    always #2 clk = ~clk;   // 250 MHz

    wide_reg_collector #(.PAGE_W(PAGE_W)) uut (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_addr(wr_addr), .wr_data(wr_data),
        .commit_valid(commit_valid), .commit_addr(commit_addr), .commit_data(commit_data),
        .narrow_valid(narrow_valid), .narrow_addr(narrow_addr), .narrow_data(narrow_data)
    );

    function automatic logic [ADDR_W-1:0] ad(input int pg, input int ofs);
        return ADDR_W'((pg << 13) | ofs);
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    // One write: compute expectation from the requirements, drive, check next cycle.
    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d, input string tag);
        logic [12:0]       ofs;
        logic              pz, narrow, ptr, owns;
        logic [1:0]        dw;
        logic [ADDR_W-5:0] blk;
        logic [3:0]        nm;
        logic              e_cv, e_nv;
        logic [ADDR_W-1:0] e_ca;
        logic [127:0]      e_cd;
        ofs    = a[12:0];
        pz     = (a[ADDR_W-1:13] == '0);
        narrow = (ofs < 13'h800) || (ofs >= 13'h1000);
        ptr    = (ofs[12:4] == 9'h083) || (ofs[12:4] == 9'h0A1);
        dw     = a[3:2];
        blk    = a[ADDR_W-1:4];
        e_cv = 1'b0; e_nv = 1'b0; e_ca = '0; e_cd = '0;
        if (narrow) begin
            e_nv = 1'b1;
            if (pz && ofs == 13'h420) m_mask = '0;
        end else begin
            owns = (m_mask == '0) || (m_blk == blk);
            nm   = m_mask | (4'b1 << dw);
            if (ptr && dw == 2'd3) begin
                e_cv = 1'b1;
                e_ca = {blk, 4'b0};
                if (owns && nm == 4'hF) e_cd = {d, m_buf[2], m_buf[1], m_buf[0]};
                else                    e_cd = {d, 96'b0};
                if (m_mask != '0 && m_blk == blk) m_mask = '0;
            end else if (owns) begin
                m_buf[dw] = d;
                m_blk     = blk;
                if (nm == 4'hF) begin
                    e_cv   = 1'b1;
                    e_ca   = {blk, 4'b0};
                    e_cd   = {m_buf[3], m_buf[2], m_buf[1], m_buf[0]};
                    m_mask = '0;
                end else begin
                    m_mask = nm;
                end
            end
        end
        wr_valid = 1'b1;
        wr_addr  = a;
        wr_data  = d;
        @(negedge clk);
        wr_valid = 1'b0;
        check(tag, "commit_valid", 128'(commit_valid), 128'(e_cv));
        if (e_cv) begin
            check(tag, "commit_addr", 128'(commit_addr), 128'(e_ca));
            check(tag, "commit_data", commit_data, e_cd);
        end
        check(tag, "narrow_valid", 128'(narrow_valid), 128'(e_nv));
        if (e_nv) begin
            check(tag, "narrow_addr", 128'(narrow_addr), 128'(a));
            check(tag, "narrow_data", 128'(narrow_data), 128'(d));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        int ofs_pick [8] = '{32'h000, 32'h420, 32'h104, 32'h800, 32'h900, 32'h830, 32'hA10, 32'h1800};
        void'($urandom(32'd1234));
        for (int i = 0; i < 4; i++) m_buf[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check("R1", "commit_valid", 128'(commit_valid), 128'(0));
        check("R1", "narrow_valid", 128'(narrow_valid), 128'(0));
        // R12: always ready
        check("R12", "wr_ready", 128'(wr_ready), 128'(1));

        // R2/R3: any-order collection; partial writes produce nothing
        wr(ad(1, 'h908), 32'h2222_0002, "R3");
        wr(ad(1, 'h900), 32'h2222_0000, "R3");
        wr(ad(1, 'h90C), 32'h2222_0003, "R3");
        wr(ad(1, 'h904), 32'h2222_0001, "R2");
        // R4: overwrite before completion; R13 new owner right after commit
        wr(ad(0, 'h800), 32'hAAAA_0000, "R13");
        wr(ad(0, 'h800), 32'hBBBB_0000, "R4");
        wr(ad(0, 'h804), 32'hBBBB_0001, "R4");
        wr(ad(0, 'h808), 32'hBBBB_0002, "R4");
        wr(ad(0, 'h80C), 32'hBBBB_0003, "R4");
        // R5/R6: pointer top dword alone -> low zero
        wr(ad(0, 'h83C), 32'hC0DE_0001, "R5");
        // R6: full pointer set
        wr(ad(1, 'hA10), 32'h1111_0000, "R6");
        wr(ad(1, 'hA14), 32'h1111_0001, "R6");
        wr(ad(1, 'hA18), 32'h1111_0002, "R6");
        wr(ad(1, 'hA1C), 32'h1111_0003, "R6");
        // R6: partial pointer set -> low zero
        wr(ad(2, 'h834), 32'h5555_0001, "R6");
        wr(ad(2, 'h83C), 32'h5555_0003, "R6");
        // R7: foreign writes dropped, owner data kept
        wr(ad(0, 'h800), 32'h7777_0000, "R7");
        wr(ad(0, 'h904), 32'hDEAD_0001, "R7");
        wr(ad(0, 'h90C), 32'hDEAD_0003, "R7");
        wr(ad(0, 'h800), 32'h7777_1000, "R7");
        wr(ad(0, 'h804), 32'h7777_0001, "R7");
        wr(ad(0, 'h808), 32'h7777_0002, "R7");
        wr(ad(0, 'h80C), 32'h7777_0003, "R7");
        // R8: pointer commit for non-owner keeps collector
        wr(ad(3, 'h900), 32'h8888_0000, "R8");
        wr(ad(3, 'hA1C), 32'h8888_FFFF, "R8");
        wr(ad(3, 'h904), 32'h8888_0001, "R8");
        wr(ad(3, 'h908), 32'h8888_0002, "R8");
        wr(ad(3, 'h90C), 32'h8888_0003, "R8");
        // R9: page-0 timer command clears collector
        wr(ad(0, 'h800), 32'h9999_0000, "R9");
        wr(ad(0, 'h420), 32'h0000_0420, "R9");
        wr(ad(0, 'h900), 32'h9999_1000, "R9");
        wr(ad(0, 'h904), 32'h9999_1001, "R9");
        wr(ad(0, 'h908), 32'h9999_1002, "R9");
        wr(ad(0, 'h90C), 32'h9999_1003, "R9");
        // R9/R11: same offset in page 1 does not clear
        wr(ad(1, 'h800), 32'h4444_0000, "R9");
        wr(ad(1, 'h420), 32'h0001_0420, "R9");
        wr(ad(1, 'h90C), 32'h4444_DEAD, "R9");
        wr(ad(1, 'h804), 32'h4444_0001, "R11");
        wr(ad(1, 'h808), 32'h4444_0002, "R11");
        wr(ad(1, 'h80C), 32'h4444_0003, "R11");
        // R10: narrow pass-through around a partial collection
        wr(ad(2, 'h800), 32'h1010_0000, "R10");
        wr(ad(2, 'h104), 32'h0202_0104, "R10");
        wr(ad(2, 'h1800), 32'h0202_1800, "R10");
        wr(ad(2, 'h804), 32'h1010_0001, "R10");
        wr(ad(2, 'h808), 32'h1010_0002, "R10");
        wr(ad(2, 'h80C), 32'h1010_0003, "R10");
        // R11: random mix across pages
        for (int i = 0; i < 600; i++) begin
            int pg  = int'($urandom_range(0, 3));
            int sel = int'($urandom_range(0, 7));
            int ln  = int'($urandom_range(0, 3));
            int ofs = ofs_pick[sel];
            if (ofs >= 'h800 && ofs < 'h1000) ofs = ofs + ln * 4;
            wr(ad(pg, ofs), $urandom(), "R11");
        end
        summary();
        $finish;
    end
endmodule